// File: doc/BRIEF.md
# Multi-Supply Reset and Watchdog Controller

This block is the digital side of a supply supervisor. Three comparator results, each high while its supply sits above its trip level, arrive asynchronously together with a power-fail comparator result and a watchdog strobe from the host processor. The block holds a system reset while any supply is low. After the last supply recovers, it keeps the reset asserted for a selectable stretch. It also raises a reset pulse of that same length when the strobe stops toggling. A separate active-low flag follows the power-fail comparator.

All counting is done in units of a free-running `tick` pulse, which comes from a divided oscillator clock. The stretch is one of four multiples of a base tick count. The watchdog window is a separate tick count. A strap input marks the strobe pin as unconnected, and that disables the watchdog. Every pin is a plain level signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `supply_supervisor`

## Requirements
- R1: While any `supply_ok_raw` bit is low, the reset is asserted. It becomes asserted no later than the third clock edge after the bit falls, because of the two-stage input synchronizer.
- R2: After all supplies are good, the reset is released exactly `limit` ticks after the synchronized last supply recovers. Counted from the clock edge at which the last input rises, the output stays asserted for `limit`+1 clock cycles when `tick` is high on every cycle.
- R3: `tmo_sel` sets `limit` to `BASE_TICKS` times a multiplier: 2'b00 gives 1x, 2'b01 gives 2x, 2'b10 gives 4x (the nominal default setting) and 2'b11 gives 8x.
- R4: If any supply drops out while the stretch is counting, the count restarts from zero and a full `limit` is counted once all supplies are good again.
- R5: Watchdog overflow occurs when the strobe shows no edge for `WDOG_TICKS` ticks while reset is released and the watchdog is enabled. Overflow asserts the reset for exactly `limit` ticks. After a release, with no strobe activity and `tick` high every cycle, the reset stays deasserted for `WDOG_TICKS` cycles.
- R6: The watchdog count is cleared while the reset is asserted and on every rising or falling edge of the synchronized strobe. Toggling the strobe at intervals shorter than the window therefore never causes a reset.
- R7: While `wdog_float` is high, the watchdog never asserts the reset, however long the strobe stays idle.
- R8: `pwr_fail_n` is low while the synchronized `pfail_ok_raw` is low and high otherwise, regardless of the reset state. It follows the input two clock edges later.
- R9: `reset_active_high` set to 1 drives `sys_reset` high when asserted. Set to 0, it drives `sys_reset` low when asserted.
- R10: During and after the asynchronous logic reset `rst_n`, the reset output is asserted. It is released only after a full `limit` count with all supplies good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| tick | input | 1 | One-cycle time base pulse from the divided oscillator |
| supply_ok_raw | input | NUM_SUPPLIES | Asynchronous supply-good comparator results, 1 = above threshold |
| pfail_ok_raw | input | 1 | Asynchronous power-fail comparator result, 1 = above trip level |
| wdog_strobe_raw | input | 1 | Asynchronous watchdog strobe from the host |
| wdog_float | input | 1 | Strap: strobe pin unconnected, watchdog disabled |
| tmo_sel | input | 2 | Stretch length select (R3 encoding) |
| reset_active_high | input | 1 | Reset output polarity, 1 = active high |
| sys_reset | output | 1 | System reset output, polarity per `reset_active_high` |
| pwr_fail_n | output | 1 | Power-fail flag, active low |

## Verification
The embedded assertions check on every cycle the relationships that hold at any instant. A synchronized supply loss forces the reset on the next edge and clears the stretch count. Release only ever happens on a tick with all supplies good. The stretch count never reaches its limit. A watchdog overflow starts a fresh stretch. The watchdog count is zero after any reset cycle or strobe edge, and the float strap blocks any overflow. Exact durations can only be shown by the bench's scenarios: the stretch measured from the last of several staggered recoveries, the four select ratios, a restart caused by a mid-count dropout, the watchdog window and the length of its pulse. The same holds for polarity and power-fail behaviour seen at the pins.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Stretch multiplier select; value n multiplies the base count by 2**n.
  typedef enum logic [1:0] {
    TMO_X1 = 2'b00,
    TMO_X2 = 2'b01,
    TMO_X4 = 2'b10,
    TMO_X8 = 2'b11
  } tmo_sel_e;

  localparam int unsigned MAX_MULT = 8;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One shift chain per bit; all bits start "not good" after logic reset.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 50,
  localparam int unsigned CNT_W     = $clog2(BASE_TICKS * MAX_MULT + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     all_ok,
  input  logic     wd_fire,
  input  tmo_sel_e sel,
  output logic     rst_q
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             at_end;

  always_comb begin
    unique case (sel)
      TMO_X1:  limit = CNT_W'(BASE_TICKS);
      TMO_X2:  limit = CNT_W'(BASE_TICKS * 2);
      TMO_X4:  limit = CNT_W'(BASE_TICKS * 4);
      default: limit = CNT_W'(BASE_TICKS * 8);
    endcase
  end

  assign at_end = (cnt >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (!all_ok || wd_fire) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (rst_q && tick) begin
      if (at_end) begin
        rst_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r1_supply_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> rst_q);
  a_r4_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> cnt == '0);
  a_r3_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);
  a_r2_release_on_good_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(all_ok && tick));
  a_r5_fire_restarts_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> rst_q && cnt == '0);

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int unsigned WDOG_TICKS = 1600,
  localparam int unsigned WD_W      = $clog2(WDOG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic strobe_s,
  input  logic wdog_float,
  input  logic rst_q,
  output logic wd_fire
);

  logic            strobe_d;
  logic            edge_seen;
  logic            clr;
  logic [WD_W-1:0] wcnt;
  logic            at_end;

  assign edge_seen = strobe_s ^ strobe_d;
  assign clr       = rst_q | edge_seen | wdog_float;
  assign at_end    = (wcnt == WD_W'(WDOG_TICKS - 1));
  assign wd_fire   = tick & ~clr & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      wcnt     <= '0;
    end else begin
      strobe_d <= strobe_s;
      if (clr || wd_fire) wcnt <= '0;
      else if (tick)      wcnt <= wcnt + WD_W'(1);
    end
  end

  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> wcnt == '0);
  a_r6_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> wcnt == '0);
  a_r7_float_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_float |-> !wd_fire);
  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < WD_W'(WDOG_TICKS));

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int unsigned NUM_SUPPLIES = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned BASE_TICKS   = 50,
  parameter int unsigned WDOG_TICKS   = 1600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [NUM_SUPPLIES-1:0] supply_ok_raw,
  input  logic                    pfail_ok_raw,
  input  logic                    wdog_strobe_raw,
  input  logic                    wdog_float,
  input  logic [1:0]              tmo_sel,
  input  logic                    reset_active_high,
  output logic                    sys_reset,
  output logic                    pwr_fail_n
);

  localparam int unsigned SYNC_W = NUM_SUPPLIES + 2;

  logic [SYNC_W-1:0]       raw_bus;
  logic [SYNC_W-1:0]       sync_bus;
  logic [NUM_SUPPLIES-1:0] supply_s;
  logic                    pfail_s;
  logic                    strobe_s;
  logic                    all_ok;
  logic                    wd_fire;
  logic                    rst_q;

  assign raw_bus = {wdog_strobe_raw, pfail_ok_raw, supply_ok_raw};

  supv_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (raw_bus),
    .q (sync_bus)
  );

  assign supply_s = sync_bus[NUM_SUPPLIES-1:0];
  assign pfail_s  = sync_bus[NUM_SUPPLIES];
  assign strobe_s = sync_bus[NUM_SUPPLIES+1];
  assign all_ok   = &supply_s;

  supv_stretch #(.BASE_TICKS(BASE_TICKS)) u_stretch (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick),
    .all_ok (all_ok),
    .wd_fire (wd_fire),
    .sel (tmo_sel_e'(tmo_sel)),
    .rst_q (rst_q)
  );

  supv_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick),
    .strobe_s (strobe_s),
    .wdog_float (wdog_float),
    .rst_q (rst_q),
    .wd_fire (wd_fire)
  );

  assign sys_reset  = reset_active_high ? rst_q : ~rst_q;
  assign pwr_fail_n = pfail_s;

  a_r8_pfail_ignores_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) && $stable(pfail_s) |-> $stable(pwr_fail_n));

endmodule

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;

  localparam int BASE = 6;
  localparam int WDOG = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] supply_ok_raw = 3'b111;
  logic       pfail_ok_raw = 1'b1;
  logic       wdog_strobe_raw = 1'b0;
  logic       wdog_float = 1'b1;
  logic [1:0] tmo_sel = 2'b10;
  logic       reset_active_high = 1'b0;
  logic       sys_reset;
  logic       pwr_fail_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  supply_supervisor #(
    .NUM_SUPPLIES(3), .SYNC_STAGES(2), .BASE_TICKS(BASE), .WDOG_TICKS(WDOG)
  ) u_supply_supervisor (
    .clk (clk), .rst_n (rst_n), .tick (tick),
    .supply_ok_raw (supply_ok_raw), .pfail_ok_raw (pfail_ok_raw),
    .wdog_strobe_raw (wdog_strobe_raw), .wdog_float (wdog_float),
    .tmo_sel (tmo_sel), .reset_active_high (reset_active_high),
    .sys_reset (sys_reset), .pwr_fail_n (pwr_fail_n)
  );

  typedef struct {
    string req;
    bit    lvl;
    int    len;
  } seg_t;

  seg_t q[$];
  bit   armed = 1'b0;
  int   run = 0;

  function automatic bit asserted_now();
    return sys_reset == reset_active_high;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input string req, input bit lvl, input int len);
    seg_t s;
    s.req = req; s.lvl = lvl; s.len = len;
    q.push_back(s);
  endtask

  task automatic arm_and_wait();
    run = 0;
    armed = 1'b1;
    while (armed) @(negedge clk);
  endtask

  // Monitor: measures each output segment and compares with the queue head.
  initial forever begin
    @(posedge clk);
    #5;
    if (armed) begin
      if (asserted_now() == q[0].lvl) run++;
      else begin
        seg_t e;
        e = q.pop_front();
        check(e.req, run, e.len);
        if (q.size() > 0) run = (asserted_now() == q[0].lvl) ? 1 : 0;
        else armed = 1'b0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3000);
    n_bad++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int limits[4];
    int idle_hits;
    limits[0] = BASE; limits[1] = BASE * 2; limits[2] = BASE * 4; limits[3] = BASE * 8;

    // R10: asserted while logic reset is held, then a full stretch
    wait_cyc(3);
    check("R10 reset state", int'(sys_reset), 0);
    push("R10/R3 power-on stretch x4", 1'b1, limits[2] + 1);
    rst_n = 1'b1;
    arm_and_wait();
    check("R10 released", int'(sys_reset), 1);

    // R1/R2/R3: one supply dropout per select setting
    for (int s = 0; s < 4; s++) begin
      tmo_sel = 2'(s);
      supply_ok_raw[s % 3] = 1'b0;
      wait_cyc(4);
      check("R1 supply low asserts", int'(asserted_now()), 1);
      supply_ok_raw[s % 3] = 1'b1;
      push("R2/R3 stretch per select", 1'b1, limits[s] + 1);
      arm_and_wait();
    end

    // R2: stretch measured from the last of staggered recoveries
    tmo_sel = 2'b01;
    supply_ok_raw = 3'b010;
    wait_cyc(4);
    supply_ok_raw[0] = 1'b1;
    wait_cyc(5);
    check("R1 one supply still low", int'(asserted_now()), 1);
    supply_ok_raw[2] = 1'b1;
    push("R2 last supply recovery", 1'b1, limits[1] + 1);
    arm_and_wait();

    // R4: dropout mid-count restarts the stretch
    tmo_sel = 2'b10;
    supply_ok_raw[1] = 1'b0;
    wait_cyc(3);
    supply_ok_raw[1] = 1'b1;
    wait_cyc(limits[2] / 2);
    supply_ok_raw[2] = 1'b0;
    wait_cyc(1);
    supply_ok_raw[2] = 1'b1;
    push("R4 restart after dropout", 1'b1, limits[2] + 1);
    arm_and_wait();

    // R8: power-fail flag independent of reset
    pfail_ok_raw = 1'b0;
    wait_cyc(3);
    check("R8 pwr_fail_n low", int'(pwr_fail_n), 0);
    check("R8 reset untouched", int'(asserted_now()), 0);
    supply_ok_raw[0] = 1'b0;
    wait_cyc(3);
    check("R8 stays low under reset", int'(pwr_fail_n), 0);
    supply_ok_raw[0] = 1'b1;
    pfail_ok_raw = 1'b1;
    wait_cyc(3);
    check("R8 pwr_fail_n high during reset", int'(pwr_fail_n), 1);
    wait_cyc(limits[2] + 2);

    // R9: active-high polarity
    reset_active_high = 1'b1;
    #1;
    check("R9 active-high idle", int'(sys_reset), 0);
    supply_ok_raw[1] = 1'b0;
    wait_cyc(4);
    check("R9 active-high asserted", int'(sys_reset), 1);
    supply_ok_raw[1] = 1'b1;
    push("R9 stretch active-high", 1'b1, limits[2] + 1);
    arm_and_wait();
    reset_active_high = 1'b0;

    // R5/R6: watchdog window and pulse length after a fresh release
    tmo_sel = 2'b00;
    wdog_float = 1'b0;
    supply_ok_raw[0] = 1'b0;
    wait_cyc(4);
    supply_ok_raw[0] = 1'b1;
    push("R5 pre-release stretch", 1'b1, limits[0] + 1);
    push("R5/R6 watchdog window", 1'b0, WDOG);
    push("R5 watchdog pulse length", 1'b1, limits[0]);
    arm_and_wait();
    wdog_float = 1'b1;
    wait_cyc(4);

    // R6: toggling both ways keeps the watchdog quiet
    wdog_float = 1'b0;
    idle_hits = 0;
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < WDOG - 8; c++) begin
        @(negedge clk);
        if (asserted_now()) idle_hits++;
      end
      wdog_strobe_raw = ~wdog_strobe_raw;
    end
    check("R6 serviced watchdog no reset", idle_hits, 0);

    // R7: float strap disables the watchdog
    wdog_float = 1'b1;
    idle_hits = 0;
    for (int c = 0; c < 4 * WDOG; c++) begin
      @(negedge clk);
      if (asserted_now()) idle_hits++;
    end
    check("R7 floating strobe no reset", idle_hits, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule